// File: doc/BRIEF.md
# Triggered Binary Hit Pipeline with Event Derandomizer

This block records one hit/no-hit bit per detector channel on every beam-crossing clock. It holds each sample in a fixed-latency circular store until the trigger decision for it arrives. A trigger takes the sample whose latency has just run out and appends it to a small queue of events. That queue smooths out bursts of triggers, which arrive at irregular times, so that readout can run at a steady pace.

Readout is serial and one event at a time. The chips on a shared link form a daisy chain and pass a token along it. A chip that receives the token and has a queued event shifts out one 128-bit event, one bit per clock, then hands the token on. A chip with an empty queue hands the token on at once. Each readout takes one event only, so a busy chip cannot hold the shared link across several events.

The hit vector and the trigger both pass through an input register. The latency is therefore counted between the clock on which the hit vector is applied and the clock on which the trigger is applied.

Top module: `hit_pipe_derand`

## Requirements
- R1: While reset is asserted and on the first clock after it, `sdata_o`, `dvalid_o`, `tok_o`, `full_o` and `ovf_o` are all 0.
- R2: Suppose a trigger is applied on clock cycle e, and at least LAT+2 cycles have passed since reset. Then the event it stores equals the hit vector applied on cycle e-LAT (LAT = 132 by default).
- R3: The queue holds up to DEPTH (8) events. `full_o` is 1 exactly while DEPTH events are stored. A trigger whose entry would arrive while the queue is full is dropped, and it sets `ovf_o`, which stays 1 until reset.
- R4: Take a token pulse applied on cycle k while the block is idle and holds an event. `dvalid_o` is then 1 for exactly NCH cycles, from cycle k+1 to k+NCH. `sdata_o` carries channel NCH-1 first and channel 0 last.
- R5: On the cycle after the last bit of an event, `tok_o` is 1 for one cycle, and the event is removed from the queue. `tok_o` and `dvalid_o` are never 1 together.
- R6: Take a token pulse applied on cycle k while the queue is empty. `tok_o` is then 1 on cycle k+1 only, and `dvalid_o` stays 0.
- R7: Events leave in the order of their triggers. A trigger and the removal of an event in the same cycle both take effect, and neither event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beam-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | NCH | Hit bits of all channels for this crossing |
| trig_i | input | 1 | Level-1 trigger pulse |
| tok_i | input | 1 | Readout token from the previous chip in the chain |
| sdata_o | output | 1 | Serial event data, channel NCH-1 first |
| dvalid_o | output | 1 | `sdata_o` carries an event bit |
| tok_o | output | 1 | Token passed to the next chip, one-cycle pulse |
| full_o | output | 1 | Event queue holds DEPTH events |
| ovf_o | output | 1 | Sticky flag: a trigger was dropped |

## Verification
The checker tests the following on every cycle:
- the token pulse and serial data never overlap;
- the token always follows the end of a data burst;
- the queue occupancy never exceeds its depth;
- the overflow flag stays set, and it only rises after a trigger that met a full queue.

Other properties can only be shown by the bench's scenarios. These are that each event's content matches the hit vector applied exactly LAT cycles before its trigger, the bit order, and the arrival order of events. They also include the one-cycle token reply on an empty queue and a trigger landing on the cycle an event is removed. For these the bench keeps its own record of applied hit vectors and a model of the queue.

// File: rtl/hit_pipe_derand.sv
`timescale 1ns/1ps
module hit_pipe_derand #(
  parameter int NCH   = 128,
  parameter int LAT   = 132,
  parameter int DEPTH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit_i,
  input  logic           trig_i,
  input  logic           tok_i,
  output logic           sdata_o,
  output logic           dvalid_o,
  output logic           tok_o,
  output logic           full_o,
  output logic           ovf_o
);
  localparam int PW = $clog2(LAT);
  localparam int FW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = $clog2(NCH);

  logic [NCH-1:0] hit_q;
  logic           trig_q;
  logic [NCH-1:0] pipe [LAT];
  logic [PW-1:0]  wp;
  logic [NCH-1:0] fifo [DEPTH];
  logic [FW-1:0]  wr, rd;
  logic [CW-1:0]  cnt;
  logic           sending;
  logic [BW-1:0]  bitc;
  logic           push, pop;

  assign push     = trig_q && (cnt != CW'(DEPTH));
  assign pop      = sending && (bitc == '0);
  assign sdata_o  = sending && fifo[rd][bitc];
  assign dvalid_o = sending;
  assign full_o   = (cnt == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q  <= '0;
      trig_q <= 1'b0;
      wp     <= '0;
    end else begin
      hit_q  <= hit_i;
      trig_q <= trig_i;
      wp     <= (wp == PW'(LAT - 1)) ? '0 : wp + PW'(1);
    end
  end

  always_ff @(posedge clk) pipe[wp] <= hit_q;

  always_ff @(posedge clk) if (push) fifo[wr] <= pipe[wp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr      <= '0;
      rd      <= '0;
      cnt     <= '0;
      ovf_o   <= 1'b0;
      sending <= 1'b0;
      bitc    <= '0;
      tok_o   <= 1'b0;
    end else begin
      if (push) wr <= (wr == FW'(DEPTH - 1)) ? '0 : wr + FW'(1);
      if (pop)  rd <= (rd == FW'(DEPTH - 1)) ? '0 : rd + FW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
      if (trig_q && !push) ovf_o <= 1'b1;
      tok_o <= pop || (!sending && tok_i && cnt == '0);
      if (sending) begin
        bitc <= bitc - BW'(1);
        if (pop) sending <= 1'b0;
      end else if (tok_i && cnt != '0) begin
        sending <= 1'b1;
        bitc    <= BW'(NCH - 1);
      end
    end
  end
endmodule

// File: rtl/hit_pipe_derand_chk.sv
`timescale 1ns/1ps
module hit_pipe_derand_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig_i,
  input logic          dvalid_o,
  input logic          tok_o,
  input logic          full_o,
  input logic          ovf_o,
  input logic [CW-1:0] cnt
);
  p_tok_no_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tok_o |-> !dvalid_o);
  p_tok_after_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dvalid_o) |-> tok_o);
  p_data_needs_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid_o |-> cnt != '0);
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
  p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(full_o) && $past(trig_i, 2));
endmodule

bind hit_pipe_derand hit_pipe_derand_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .dvalid_o(dvalid_o),
  .tok_o(tok_o), .full_o(full_o), .ovf_o(ovf_o), .cnt(cnt)
);

// File: tb/sim_hit_pipe_derand.sv
`timescale 1ns/1ps
module sim_hit_pipe_derand;
  localparam real CLK_NS = 25.0;
  localparam int  NCH = 128, LAT = 132, DEPTH = 8, NCYC = 4200;

  logic clk = 1'b0, rst_n = 1'b0, trig_i = 1'b0, tok_i = 1'b0;
  logic [NCH-1:0] hit_i = '0;
  logic sdata_o, dvalid_o, tok_o, full_o, ovf_o;
  int nchk = 0, nfail = 0;

  hit_pipe_derand #(.NCH(NCH), .LAT(LAT), .DEPTH(DEPTH)) u0 (.*);

  always #(CLK_NS / 2.0) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit want_trig(input int i);
    if (i < LAT + 3) return 1'b0;
    if (i >= 150 && i < 166) return 1'b1;
    if (i < 170) return 1'b0;
    return (i < 2500) ? ($urandom % 16 == 0) : ($urandom % 4 == 0);
  endfunction

  initial begin
    #(CLK_NS * 200000.0);
    nfail++;
    $display("FAIL R4 watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [NCH-1:0] hist [256];
    logic [NCH-1:0] q [$];
    logic [NCH-1:0] ev;
    bit sending, tok_exp, ovf_exp, trig_prev, tk, tg;
    string tok_req;
    int nb;
    void'($urandom(32'd20021206));
    ev = '0; sending = 0; tok_exp = 0; ovf_exp = 0; trig_prev = 0; nb = 0; tok_req = "R5";
    repeat (4) @(negedge clk);
    chk({sdata_o, dvalid_o, tok_o, full_o, ovf_o} == 5'b0, "R1 reset", NCH'({sdata_o, dvalid_o, tok_o, full_o, ovf_o}), '0);
    rst_n = 1'b1;
    for (int i = 0; i < NCYC; i++) begin
      @(negedge clk);
      if (i == 0) chk({sdata_o, dvalid_o, tok_o, full_o, ovf_o} == 5'b0, "R1 after reset", NCH'({sdata_o, dvalid_o, tok_o, full_o, ovf_o}), '0);
      chk(tok_o == tok_exp, tok_req, NCH'(tok_o), NCH'(tok_exp));
      chk(dvalid_o == sending, "R4 valid window", NCH'(dvalid_o), NCH'(sending));
      chk(full_o == (q.size() == DEPTH), "R3 full", NCH'(full_o), NCH'(q.size() == DEPTH));
      chk(ovf_o == ovf_exp, "R3 overflow", NCH'(ovf_o), NCH'(ovf_exp));
      tok_exp = 0;
      if (trig_prev) begin
        if (q.size() < DEPTH) q.push_back(hist[(i - 1 - LAT) & 255]);
        else ovf_exp = 1;
      end
      if (dvalid_o && sending) begin
        ev = {ev[NCH-2:0], sdata_o};
        nb++;
        if (nb == NCH) begin
          chk(ev == q[0], "R2 R7 event content", ev, q[0]);
          void'(q.pop_front());
          sending = 0; nb = 0; tok_exp = 1; tok_req = "R5 token after event";
        end
      end
      tk = 0;
      if (!sending && !tok_exp && !trig_prev) begin
        if (i == LAT + 2) tk = 1;
        else if (i >= 170) tk = ($urandom % 2 == 0);
      end
      if (tk) begin
        if (q.size() == 0) begin tok_exp = 1; tok_req = "R6 empty token"; end
        else sending = 1;
      end
      tg = want_trig(i);
      hit_i = {$urandom, $urandom, $urandom, $urandom};
      trig_i = tg;
      tok_i = tk;
      hist[i & 255] = hit_i;
      trig_prev = tg;
      if (!tok_exp) tok_req = "R5 unexpected token";
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule